// File: doc/BRIEF.md
# Programmable Interval Timer with Port Registers

A small memory-mapped peripheral for a processor bus. It holds a command/status register, three parallel output port registers and a 14-bit down-counter. The counter drives a single output pin. Software writes a count and an output mode, then issues a start command. The pin then produces a square wave, for example a tone on a buzzer whose pitch follows the count, or a one-cycle low pulse at each terminal count. Either shape can run once or repeat.

Software reaches the block through a 3-bit offset, write and read strobes and an 8-bit data bus. Writes take effect on the clock edge at which the write strobe is high. Read data is a combinational function of the offset. The count is split over two byte registers: the high byte carries the six upper count bits and, in bits 7:6, the mode. The count and mode only take effect through a START command. A START issued while the counter runs is held until the current period ends, so the waveform switches without a break.

Top module: `pit_top`

## Requirements
- R1: After reset, all three port registers and the status byte read 0, `timer_out` is high and the counter is idle.
- R2: Offsets 1 and 2 are 8-bit port registers A and B, and offset 3 is the 6-bit port C register. Each drives its output pins from the write edge onward and reads back at its offset. The unused upper bits of port C read 0.
- R3: Offset 4 holds count bits 7:0. Offset 5 holds count bits 13:8 in bits 5:0 and the mode in bits 7:6. Both read back as written.
- R4: Mode 01 is a continuous square wave. With count N, counting from the START write edge, the output is high for the first ceil(N/2) cycles and low for the remaining floor(N/2) cycles. It repeats every N cycles.
- R5: Mode 11 is a continuous pulse. The output is low only in the last cycle of each N-cycle period, and the count reloads automatically.
- R6: Mode 00 (single square wave) and mode 10 (single pulse) produce one period of the corresponding shape. The output then stays high with the counter idle.
- R7: Command bits 7:6 written to offset 0 select the action: 00 none, 01 stop, 10 stop at terminal count, 11 start. Command 01 stops counting at once and returns the output high. On an idle counter it has no effect.
- R8: Command 10 lets the current period finish and then stops. On an idle counter it has no effect: a later START runs normally.
- R9: START on an idle counter loads the mode and count and begins counting at the write edge. START on a running counter takes effect after the current terminal count. Writes to offsets 4 and 5 without a START do not alter the running waveform.
- R10: Reset halts counting but keeps the count and mode. A START after reset, with no new count written, uses the previously loaded values.
- R11: A START with a count of 0 or 1 does not start the counter. The output stays high and no terminal count is flagged.
- R12: Reading offset 0 returns the terminal-count flag in bit 7, with all other bits 0. The flag is set at every terminal count and cleared by a read strobe at offset 0. A terminal count in the same cycle as that read wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (clears the status flag at offset 0) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current offset |
| pa_out | output | 8 | Port A pins |
| pb_out | output | 8 | Port B pins |
| pc_out | output | 6 | Port C pins |
| timer_out | output | 1 | Timer output pin |

## Verification
The bench goes after odd counts, where a design that splits the square wave the wrong way would lengthen the low half instead of the high half. It also checks the shortest legal count of 2, and counts of 0 and 1, where a careless design would start a counter that underflows and toggles forever. It checks a START issued mid-period: a design that loads at once truncates the old period, and one that never loads keeps the old period forever. It also checks stop-at-terminal-count, reset in the middle of a run, and the clear-on-read flag. Each of these would show up as a wrong output level in a specific cycle, or as a flag that sticks or never appears.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int CNT_W  = 14;
    localparam int LO_W   = DATA_W;
    localparam int HI_W   = CNT_W - LO_W;

    localparam logic [ADDR_W-1:0] OFS_CMD = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_PA  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_PB  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_PC  = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_TLO = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_THI = 3'd5;

    typedef enum logic [1:0] {
        CMD_NOP     = 2'b00,
        CMD_STOP    = 2'b01,
        CMD_STOP_TC = 2'b10,
        CMD_START   = 2'b11
    } tcmd_e;

    typedef enum logic [1:0] {
        MODE_SQ_ONE    = 2'b00,
        MODE_SQ_RUN    = 2'b01,
        MODE_PULSE_ONE = 2'b10,
        MODE_PULSE_RUN = 2'b11
    } tmode_e;

    typedef struct packed {
        tmode_e           mode;
        logic [CNT_W-1:0] len;
    } tcfg_t;

    function automatic logic is_loop(tmode_e m);
        return m[0];
    endfunction

    function automatic logic len_ok(logic [CNT_W-1:0] n);
        return n > CNT_W'(1);
    endfunction

    function automatic logic wave_level(tcfg_t c, logic [CNT_W-1:0] rem);
        if (!c.mode[1])
            return rem > (c.len >> 1);
        return rem != CNT_W'(1);
    endfunction
endpackage

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
#(
    parameter int PC_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tc_evt,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] pa_q,
    output logic [DATA_W-1:0] pb_q,
    output logic [PC_W-1:0]   pc_q,
    output logic              cmd_valid,
    output tcmd_e             cmd,
    output tcfg_t             cfg,
    output logic              tc_flag
);
    localparam int PC_PAD = DATA_W - PC_W;

    logic [LO_W-1:0] len_lo;
    logic [HI_W-1:0] len_hi;
    tmode_e          mode_q;

    assign cmd_valid = wr_en && (addr == OFS_CMD);
    assign cmd       = tcmd_e'(wdata[DATA_W-1 -: 2]);
    assign cfg       = '{mode: mode_q, len: {len_hi, len_lo}};

    always_ff @(posedge clk) begin
        if (rst) begin
            pa_q <= '0;
            pb_q <= '0;
            pc_q <= '0;
        end else if (wr_en) begin
            if (addr == OFS_PA) pa_q <= wdata;
            if (addr == OFS_PB) pb_q <= wdata;
            if (addr == OFS_PC) pc_q <= wdata[PC_W-1:0];
        end
    end

    // count and mode survive reset by design
    always_ff @(posedge clk) begin
        if (wr_en && addr == OFS_TLO) len_lo <= wdata;
        if (wr_en && addr == OFS_THI) begin
            len_hi <= wdata[HI_W-1:0];
            mode_q <= tmode_e'(wdata[DATA_W-1 -: 2]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            tc_flag <= 1'b0;
        else if (tc_evt)
            tc_flag <= 1'b1;
        else if (rd_en && addr == OFS_CMD)
            tc_flag <= 1'b0;
    end

    always_comb begin
        case (addr)
            OFS_CMD: rdata = {tc_flag, {(DATA_W-1){1'b0}}};
            OFS_PA:  rdata = pa_q;
            OFS_PB:  rdata = pb_q;
            OFS_PC:  rdata = {{PC_PAD{1'b0}}, pc_q};
            OFS_TLO: rdata = len_lo;
            OFS_THI: rdata = {mode_q, len_hi};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/pit_counter.sv
module pit_counter
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  tcmd_e            cmd,
    input  tcfg_t            cfg,
    output logic             run_q,
    output logic             pend_q,
    output logic             stc_q,
    output logic [CNT_W-1:0] rem_q,
    output tcfg_t            act_q,
    output logic             tc_evt,
    output logic             wave_out
);
    logic n_run, n_pend, n_stc, load_new, reload;

    assign tc_evt = run_q && (rem_q == CNT_W'(1));

    always_comb begin
        n_run    = run_q;
        n_pend   = pend_q;
        n_stc    = stc_q;
        load_new = 1'b0;
        reload   = 1'b0;
        if (tc_evt) begin
            if (pend_q) begin
                load_new = len_ok(cfg.len);
                n_run    = len_ok(cfg.len);
                n_pend   = 1'b0;
                n_stc    = 1'b0;
            end else if (stc_q || !is_loop(act_q.mode)) begin
                n_run = 1'b0;
                n_stc = 1'b0;
            end else begin
                reload = 1'b1;
            end
        end
        if (cmd_valid) begin
            case (cmd)
                CMD_STOP: if (run_q) begin
                    n_run    = 1'b0;
                    n_pend   = 1'b0;
                    n_stc    = 1'b0;
                    load_new = 1'b0;
                    reload   = 1'b0;
                end
                CMD_STOP_TC: if (run_q) begin
                    n_stc  = n_run;
                    n_pend = 1'b0;
                end
                CMD_START: if (!run_q || tc_evt) begin
                    load_new = len_ok(cfg.len);
                    n_run    = len_ok(cfg.len);
                    n_pend   = 1'b0;
                    n_stc    = 1'b0;
                    reload   = 1'b0;
                end else begin
                    n_pend = 1'b1;
                    n_stc  = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            pend_q <= 1'b0;
            stc_q  <= 1'b0;
        end else begin
            run_q  <= n_run;
            pend_q <= n_pend;
            stc_q  <= n_stc;
        end
    end

    // counter and active setting are not preset by reset
    always_ff @(posedge clk) begin
        if (load_new) begin
            rem_q <= cfg.len;
            act_q <= cfg;
        end else if (reload) begin
            rem_q <= act_q.len;
        end else if (run_q) begin
            rem_q <= rem_q - CNT_W'(1);
        end
    end

    assign wave_out = !run_q || wave_level(act_q, rem_q);
endmodule

// File: rtl/pit_top.sv
module pit_top
    import pit_pkg::*;
#(
    parameter int PC_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] pa_out,
    output logic [DATA_W-1:0] pb_out,
    output logic [PC_W-1:0]   pc_out,
    output logic              timer_out
);
    logic             cmd_valid, tc_evt, tc_flag;
    logic             t_run, t_pend, t_stc;
    logic [CNT_W-1:0] t_rem;
    tcmd_e            cmd;
    tcfg_t            cfg, t_act;

    pit_regs #(.PC_W(PC_W)) u_regs (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .tc_evt(tc_evt), .rdata(rdata),
        .pa_q(pa_out), .pb_q(pb_out), .pc_q(pc_out),
        .cmd_valid(cmd_valid), .cmd(cmd), .cfg(cfg), .tc_flag(tc_flag)
    );

    pit_counter u_cnt (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .cfg(cfg),
        .run_q(t_run), .pend_q(t_pend), .stc_q(t_stc), .rem_q(t_rem),
        .act_q(t_act), .tc_evt(tc_evt), .wave_out(timer_out)
    );
endmodule

// File: rtl/pit_checker.sv
module pit_checker
    import pit_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] pa_out,
    input logic              timer_out,
    input logic              cmd_valid,
    input tcmd_e             cmd,
    input tcfg_t             cfg,
    input logic              t_run,
    input logic              t_pend,
    input logic              t_stc,
    input logic [CNT_W-1:0]  t_rem,
    input tcfg_t             t_act,
    input logic              tc_evt,
    input logic              tc_flag
);
    a_r2_port_a_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_PA) |=> pa_out == $past(wdata));

    a_r4_decrement: assert property (@(posedge clk) disable iff (rst)
        (t_run && !tc_evt && !cmd_valid) |=> t_rem == $past(t_rem) - CNT_W'(1));

    a_r5_reload: assert property (@(posedge clk) disable iff (rst)
        (tc_evt && !t_pend && !t_stc && t_act.mode[0] && !cmd_valid)
        |=> (t_run && t_rem == $past(t_act.len)));

    a_r6_single_end: assert property (@(posedge clk) disable iff (rst)
        (tc_evt && !t_pend && !t_act.mode[0] && !cmd_valid) |=> (!t_run && timer_out));

    a_r7_stop_now: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd == CMD_STOP) |=> (!t_run && timer_out));

    a_r11_no_start: assert property (@(posedge clk) disable iff (rst)
        (!t_run && cmd_valid && cmd == CMD_START && cfg.len < CNT_W'(2)) |=> !t_run);

    a_r12_flag_set: assert property (@(posedge clk) disable iff (rst)
        tc_evt |=> tc_flag);
endmodule

bind pit_top pit_checker u_chk (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .pa_out(pa_out), .timer_out(timer_out), .cmd_valid(cmd_valid), .cmd(cmd),
    .cfg(cfg), .t_run(t_run), .t_pend(t_pend), .t_stc(t_stc), .t_rem(t_rem),
    .t_act(t_act), .tc_evt(tc_evt), .tc_flag(tc_flag)
);

// File: tb/tb_pit_top.sv
`timescale 1ns/1ps
module tb_pit_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, pa_out, pb_out;
    logic [5:0] pc_out;
    logic       timer_out;
    int checks = 0, errors = 0;
    bit done = 0;

    typedef struct packed {
        logic [1:0]  mode;
        logic [13:0] len;
    } vec_t;
    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 14'd6}, '{2'd1, 14'd7}, '{2'd3, 14'd5},
        '{2'd0, 14'd4}, '{2'd2, 14'd3}, '{2'd1, 14'd2}
    };

    pit_top dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .pa_out(pa_out), .pb_out(pb_out),
        .pc_out(pc_out), .timer_out(timer_out)
    );

    always #10 clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_level(logic [1:0] mode, int n, int k);
        int rem;
        if (n < 2) return 1'b1;
        if (!mode[0] && k >= n) return 1'b1;
        rem = n - (k % n);
        if (!mode[1]) return rem > (n / 2);
        return rem != 1;
    endfunction

    // all tasks start and end at a falling edge
    task automatic wr(logic [2:0] a, logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic load_cfg(logic [1:0] mode, logic [13:0] n);
        wr(3'd4, n[7:0]);
        wr(3'd5, {mode, n[13:8]});
    endtask

    task automatic run_wave(string tag, logic [1:0] mode, int n, int k0, int cycles);
        for (int k = k0; k < k0 + cycles; k++) begin
            chk(tag, timer_out, exp_level(mode, n, k));
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 timer_out", timer_out, 1);
        rd(3'd0, d); chk("R1 status", d, 8'h00);
        rd(3'd1, d); chk("R1 port A", d, 8'h00);
        chk("R1 port B pins", pb_out, 8'h00);
        chk("R1 port C pins", pc_out, 6'h00);

        // R2 ports
        wr(3'd1, 8'h5A); chk("R2 pa_out", pa_out, 8'h5A);
        wr(3'd2, 8'hC3); chk("R2 pb_out", pb_out, 8'hC3);
        wr(3'd3, 8'hFF); chk("R2 pc_out", pc_out, 6'h3F);
        rd(3'd1, d); chk("R2 read A", d, 8'h5A);
        rd(3'd2, d); chk("R2 read B", d, 8'hC3);
        rd(3'd3, d); chk("R2 read C", d, 8'h3F);

        // R3 count/mode readback
        wr(3'd4, 8'hA5); wr(3'd5, 8'hAB);
        rd(3'd4, d); chk("R3 low byte", d, 8'hA5);
        rd(3'd5, d); chk("R3 high byte", d, 8'hAB);

        // vector table: R4 / R5 / R6 waveforms
        for (int i = 0; i < NV; i++) begin
            string tag;
            int n;
            n = int'(VECS[i].len);
            case (VECS[i].mode)
                2'd1: tag = "R4 square run";
                2'd3: tag = "R5 pulse run";
                default: tag = "R6 single";
            endcase
            load_cfg(VECS[i].mode, VECS[i].len);
            wr(3'd0, 8'hC0);
            run_wave(tag, VECS[i].mode, n, 0, 3 * n);
            wr(3'd0, 8'h40);
        end

        // R7 immediate stop, then stop on idle
        load_cfg(2'd1, 14'd10);
        wr(3'd0, 8'hC0);
        chk("R7 running high", timer_out, 1);
        wr(3'd0, 8'h40);
        for (int k = 1; k < 9; k++) begin
            chk("R7 stopped high", timer_out, 1);
            @(negedge clk);
        end
        wr(3'd0, 8'h40);
        chk("R7 idle stop", timer_out, 1);

        // R8 stop at terminal count
        load_cfg(2'd3, 14'd4);
        wr(3'd0, 8'hC0);
        chk("R8 k0", timer_out, 1);
        wr(3'd0, 8'h80);
        for (int k = 1; k < 10; k++) begin
            chk("R8 stop after tc", timer_out, (k == 3) ? 1'b0 : 1'b1);
            @(negedge clk);
        end
        // R8 idle: no effect on a later start
        wr(3'd0, 8'h80);
        load_cfg(2'd1, 14'd4);
        wr(3'd0, 8'hC0);
        run_wave("R8 idle no effect", 2'd1, 4, 0, 12);
        wr(3'd0, 8'h40);

        // R9 deferred start
        load_cfg(2'd1, 14'd8);
        wr(3'd0, 8'hC0);
        chk("R9 old k0", timer_out, exp_level(2'd1, 8, 0));
        wr(3'd4, 8'd4);
        chk("R9 old k1", timer_out, exp_level(2'd1, 8, 1));
        wr(3'd5, 8'h40);
        chk("R9 old k2", timer_out, exp_level(2'd1, 8, 2));
        wr(3'd0, 8'hC0);
        run_wave("R9 old period", 2'd1, 8, 3, 5);
        run_wave("R9 new period", 2'd1, 4, 0, 12);
        wr(3'd0, 8'h40);

        // R10 reset keeps count and mode
        load_cfg(2'd1, 14'd6);
        wr(3'd0, 8'hC0);
        repeat (2) @(negedge clk);
        do_reset();
        for (int k = 0; k < 8; k++) begin
            chk("R10 halted high", timer_out, 1);
            @(negedge clk);
        end
        rd(3'd1, d); chk("R1 port A after reset", d, 8'h00);
        rd(3'd0, d); chk("R1 status after reset", d, 8'h00);
        wr(3'd0, 8'hC0);
        run_wave("R10 restart old cfg", 2'd1, 6, 0, 12);
        wr(3'd0, 8'h40);

        // R11 illegal counts
        rd(3'd0, d);
        load_cfg(2'd1, 14'd1);
        wr(3'd0, 8'hC0);
        for (int k = 0; k < 6; k++) begin
            chk("R11 count 1 high", timer_out, 1);
            @(negedge clk);
        end
        load_cfg(2'd3, 14'd0);
        wr(3'd0, 8'hC0);
        for (int k = 0; k < 6; k++) begin
            chk("R11 count 0 high", timer_out, 1);
            @(negedge clk);
        end
        rd(3'd0, d); chk("R11 no flag", d, 8'h00);

        // R12 flag set and clear on read
        load_cfg(2'd0, 14'd3);
        wr(3'd0, 8'hC0);
        repeat (5) @(negedge clk);
        rd(3'd0, d); chk("R12 flag set", d, 8'h80);
        rd(3'd0, d); chk("R12 flag cleared", d, 8'h00);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule